// File: doc/BRIEF.md
# Accumulator Machine Control Sequencer

This block is the multi-cycle control unit of a 16-bit accumulator machine whose instructions name a single memory operand. It holds the program counter, memory address register, data register, instruction register, accumulator and an interrupt-enable flag. It steps through a fixed schedule of register transfers for each instruction: fetch, decode, an optional indirect-address pass, then execute. Between instructions it may take an interrupt. It drives a synchronous single-port memory through one address bus, a read strobe, a write strobe and a write-data bus. Read data comes back one cycle after the read strobe.

Two opcodes are decoded. STORE writes the accumulator to the operand address. NOP does nothing beyond the fetch. Other opcodes are treated as NOP. For indirect STORE, a second memory read fetches a pointer word, and its low bits replace the address field of the instruction register. When the interrupt is taken, the PC passes through the data register and is written to a fixed save location with an ordinary memory write. The PC is then loaded with the service-routine address, and the enable flag is cleared. The accumulator is loaded by the surrounding datapath through a load port.

Top module: `acc_seq_ctrl`

## Requirements
- R1: Reset sets pc to RESET_PC (default 0), clears the interrupt-enable flag, and holds mem_re and mem_we low.
- R2: After reset, the first fetch places mem_re high with mem_addr equal to the PC in the second cycle. pc increases by exactly one at the end of that cycle. The read strobe never stays high for two cycles running.
- R3: The instruction word has opcode bits [15:12], the indirect flag at bit [11] and the address at bits [10:0]. Opcode 4'h1 is STORE. Opcode 4'h0 (NOP) and every other opcode make no memory write, whatever the indirect flag holds.
- R4: A direct STORE (bit 11 clear) makes exactly one single-cycle write of the accumulator value to the address field.
- R5: An indirect STORE (bit 11 set) first reads the word at the address field. It then writes the accumulator to the low 11 bits of that word.
- R6: At the end of an instruction, if irq is high and the enable flag is set, the block writes the address of the next instruction to SAVE_ADDR. It then loads pc with ISR_ADDR and clears the enable flag. The flag falls only on such an entry.
- R7: With the enable flag clear, irq has no effect. After an entry, the sequence is not entered again while the flag stays clear.
- R8: mem_re and mem_we are never high in the same cycle.
- R9: pc changes only by an increment of one or by a load of ISR_ADDR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq | input | 1 | Interrupt request, level sampled at instruction end |
| ie_set | input | 1 | Sets the interrupt-enable flag |
| ac_ld | input | 1 | Loads the accumulator from ac_din |
| ac_din | input | 16 | Accumulator load value |
| mem_rdata | input | 16 | Memory read data, valid one cycle after mem_re |
| mem_addr | output | 11 | Memory address (MAR) |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 16 | Memory write data |
| pc | output | 11 | Program counter |
| ie | output | 1 | Interrupt-enable flag |

## Verification
The assertions assume that the memory returns read data exactly one cycle after the strobe. They also assume that irq and ie_set are stable around the rising edge. The bench meets both assumptions: its memory model registers the read word on the strobe edge, and all inputs change on the falling edge. The PC-step property takes for granted that ISR_ADDR is the only value loaded into the PC other than an increment. The bench therefore checks the reset value of the PC at the ports and not through that property.

// File: rtl/acs_pkg.sv
package acs_pkg;

   localparam int unsigned OPC_W = 4;
   localparam logic [OPC_W-1:0] OPC_NOP   = 4'h0;
   localparam logic [OPC_W-1:0] OPC_STORE = 4'h1;

   typedef enum logic [3:0] {
      ST_F_MAR, ST_F_RD, ST_F_DR, ST_F_IR, ST_DEC,
      ST_I_MAR, ST_I_RD, ST_I_DR, ST_I_IR,
      ST_X_MAR, ST_X_WR,
      ST_Q_DR, ST_Q_MAR, ST_Q_WR, ST_Q_PC
   } acs_state_e;

   typedef struct packed {
      logic pc_inc;
      logic pc_isr;
      logic mar_pc;
      logic mar_ir;
      logic mar_dr;
      logic mar_save;
      logic dr_mem;
      logic dr_pc;
      logic ir_dr;
      logic ir_addr_dr;
      logic ie_clr;
      logic mem_re;
      logic mem_we;
      logic wsel_dr;
   } acs_ctrl_t;

endpackage

// File: rtl/acs_fsm.sv
module acs_fsm
   import acs_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [OPC_W-1:0] opcode,
   input  logic             ind,
   input  logic             irq,
   input  logic             ie,
   output acs_ctrl_t        ctrl
);

   acs_state_e state_q, state_d;

   // where to go once an instruction has finished
   acs_state_e after_instr;
   assign after_instr = (irq && ie) ? ST_Q_DR : ST_F_MAR;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_F_MAR;
      else        state_q <= state_d;
   end

   always_comb begin
      ctrl    = '0;
      state_d = state_q;
      unique case (state_q)
         ST_F_MAR: begin ctrl.mar_pc = 1'b1; state_d = ST_F_RD; end
         ST_F_RD:  begin ctrl.mem_re = 1'b1; ctrl.pc_inc = 1'b1; state_d = ST_F_DR; end
         ST_F_DR:  begin ctrl.dr_mem = 1'b1; state_d = ST_F_IR; end
         ST_F_IR:  begin ctrl.ir_dr  = 1'b1; state_d = ST_DEC; end
         ST_DEC: begin
            if (opcode == OPC_STORE) state_d = ind ? ST_I_MAR : ST_X_MAR;
            else                     state_d = after_instr;
         end
         ST_I_MAR: begin ctrl.mar_dr = 1'b1; state_d = ST_I_RD; end
         ST_I_RD:  begin ctrl.mem_re = 1'b1; state_d = ST_I_DR; end
         ST_I_DR:  begin ctrl.dr_mem = 1'b1; state_d = ST_I_IR; end
         ST_I_IR:  begin ctrl.ir_addr_dr = 1'b1; state_d = ST_X_MAR; end
         ST_X_MAR: begin ctrl.mar_ir = 1'b1; state_d = ST_X_WR; end
         ST_X_WR:  begin ctrl.mem_we = 1'b1; state_d = after_instr; end
         ST_Q_DR:  begin ctrl.dr_pc = 1'b1; ctrl.ie_clr = 1'b1; state_d = ST_Q_MAR; end
         ST_Q_MAR: begin ctrl.mar_save = 1'b1; state_d = ST_Q_WR; end
         ST_Q_WR:  begin ctrl.mem_we = 1'b1; ctrl.wsel_dr = 1'b1; state_d = ST_Q_PC; end
         ST_Q_PC:  begin ctrl.pc_isr = 1'b1; state_d = ST_F_MAR; end
         default:  state_d = ST_F_MAR;
      endcase
   end

endmodule

// File: rtl/acs_dpath.sv
module acs_dpath
   import acs_pkg::*;
#(
   parameter int unsigned ADDR_W    = 11,
   parameter int unsigned DATA_W    = 16,
   parameter logic [ADDR_W-1:0] RESET_PC  = '0,
   parameter logic [ADDR_W-1:0] SAVE_ADDR = '1,
   parameter logic [ADDR_W-1:0] ISR_ADDR  = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  acs_ctrl_t         ctrl,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              ac_ld,
   input  logic [DATA_W-1:0] ac_din,
   input  logic              ie_set,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic [ADDR_W-1:0] pc,
   output logic [OPC_W-1:0]  opcode,
   output logic              ind,
   output logic              ie
);

   localparam int unsigned IND_BIT = ADDR_W;
   localparam int unsigned PAD_W   = DATA_W - ADDR_W;

   logic [ADDR_W-1:0] pc_q, mar_q;
   logic [DATA_W-1:0] dr_q, ir_q, ac_q;
   logic              ie_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q  <= RESET_PC;
         mar_q <= '0;
         dr_q  <= '0;
         ir_q  <= '0;
         ac_q  <= '0;
         ie_q  <= 1'b0;
      end else begin
         if (ctrl.pc_isr)      pc_q <= ISR_ADDR;
         else if (ctrl.pc_inc) pc_q <= pc_q + 1'b1;

         if (ctrl.mar_pc)        mar_q <= pc_q;
         else if (ctrl.mar_ir)   mar_q <= ir_q[ADDR_W-1:0];
         else if (ctrl.mar_dr)   mar_q <= dr_q[ADDR_W-1:0];
         else if (ctrl.mar_save) mar_q <= SAVE_ADDR;

         if (ctrl.dr_mem)     dr_q <= mem_rdata;
         else if (ctrl.dr_pc) dr_q <= {{PAD_W{1'b0}}, pc_q};

         if (ctrl.ir_dr)           ir_q <= dr_q;
         else if (ctrl.ir_addr_dr) ir_q[ADDR_W-1:0] <= dr_q[ADDR_W-1:0];

         if (ac_ld) ac_q <= ac_din;

         if (ctrl.ie_clr)  ie_q <= 1'b0;
         else if (ie_set)  ie_q <= 1'b1;
      end
   end

   assign mem_addr  = mar_q;
   assign mem_wdata = ctrl.wsel_dr ? dr_q : ac_q;
   assign pc        = pc_q;
   assign opcode    = ir_q[DATA_W-1 -: OPC_W];
   assign ind       = ir_q[IND_BIT];
   assign ie        = ie_q;

endmodule

// File: rtl/acc_seq_ctrl.sv
module acc_seq_ctrl
   import acs_pkg::*;
#(
   parameter int unsigned ADDR_W    = 11,
   parameter int unsigned DATA_W    = 16,
   parameter logic [ADDR_W-1:0] RESET_PC  = 11'h000,
   parameter logic [ADDR_W-1:0] SAVE_ADDR = 11'h7F0,
   parameter logic [ADDR_W-1:0] ISR_ADDR  = 11'h200
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              irq,
   input  logic              ie_set,
   input  logic              ac_ld,
   input  logic [DATA_W-1:0] ac_din,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_re,
   output logic              mem_we,
   output logic [DATA_W-1:0] mem_wdata,
   output logic [ADDR_W-1:0] pc,
   output logic              ie
);

   localparam int unsigned FIELD_SUM = OPC_W + 1 + ADDR_W;

   generate
      if (FIELD_SUM != DATA_W) begin : g_bad_format
         $error("opcode, indirect flag and address must fill the word");
      end
      if (ISR_ADDR == SAVE_ADDR) begin : g_bad_vectors
         $error("save location must differ from service entry");
      end
   endgenerate

   acs_ctrl_t        ctrl;
   logic [OPC_W-1:0] opcode;
   logic             ind;

   acs_fsm u_fsm (
      .clk    (clk),
      .rst_n  (rst_n),
      .opcode (opcode),
      .ind    (ind),
      .irq    (irq),
      .ie     (ie),
      .ctrl   (ctrl)
   );

   acs_dpath #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .RESET_PC  (RESET_PC),
      .SAVE_ADDR (SAVE_ADDR),
      .ISR_ADDR  (ISR_ADDR)
   ) u_dpath (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctrl      (ctrl),
      .mem_rdata (mem_rdata),
      .ac_ld     (ac_ld),
      .ac_din    (ac_din),
      .ie_set    (ie_set),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .pc        (pc),
      .opcode    (opcode),
      .ind       (ind),
      .ie        (ie)
   );

   assign mem_re = ctrl.mem_re;
   assign mem_we = ctrl.mem_we;

endmodule

// File: rtl/acs_checker.sv
module acs_checker #(
   parameter int unsigned ADDR_W = 11,
   parameter logic [ADDR_W-1:0] ISR_ADDR = '0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              irq,
   input logic              mem_re,
   input logic              mem_we,
   input logic [ADDR_W-1:0] pc,
   input logic              ie
);

   assert_rw_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_re && mem_we));

   assert_single_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> !mem_we);

   assert_single_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_re |=> !mem_re);

   assert_pc_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pc) |-> (pc == ADDR_W'($past(pc) + 1'b1) || pc == ISR_ADDR));

   assert_ie_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ie) |-> $past(irq));

endmodule

bind acc_seq_ctrl acs_checker #(.ADDR_W(ADDR_W), .ISR_ADDR(ISR_ADDR)) u_acs_checker (
   .clk    (clk),
   .rst_n  (rst_n),
   .irq    (irq),
   .mem_re (mem_re),
   .mem_we (mem_we),
   .pc     (pc),
   .ie     (ie)
);

// File: tb/test_acc_seq_ctrl.sv
module test_acc_seq_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 11;
   localparam int DW = 16;
   localparam logic [AW-1:0] SAVE_A = 11'h7F0;
   localparam logic [AW-1:0] ISR_A  = 11'h200;

   // {instr, pointer word, acc value, expect write, expect address}
   localparam int NV = 8;
   localparam logic [59:0] VEC [NV] = '{
      {16'h1040, 16'h0000, 16'hA5A5, 1'b1, 11'h040},
      {16'h17FF, 16'h0000, 16'h0001, 1'b1, 11'h7FF},
      {16'h1900, 16'hF234, 16'h1234, 1'b1, 11'h234},
      {16'h1802, 16'h0005, 16'hFFFF, 1'b1, 11'h005},
      {16'h1FFF, 16'h0ABC, 16'h0F0F, 1'b1, 11'h2BC},
      {16'h1000, 16'h0000, 16'h5555, 1'b1, 11'h000},
      {16'h0FFF, 16'h0033, 16'h7777, 1'b0, 11'h000},
      {16'h2040, 16'h0000, 16'h3C3C, 1'b0, 11'h000}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic irq = 1'b0, ie_set = 1'b0, ac_ld = 1'b0;
   logic [DW-1:0] ac_din = '0;
   logic [DW-1:0] mem_rdata;
   logic [AW-1:0] mem_addr, pc;
   logic mem_re, mem_we, ie;
   logic [DW-1:0] mem_wdata;

   logic [DW-1:0] mem [2**AW];
   logic log_clr = 1'b0;
   int wcnt;
   logic [AW-1:0] last_a;
   logic [DW-1:0] last_d;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   acc_seq_ctrl #(.SAVE_ADDR(SAVE_A), .ISR_ADDR(ISR_A)) i_acc_seq_ctrl (
      .clk(clk), .rst_n(rst_n), .irq(irq), .ie_set(ie_set),
      .ac_ld(ac_ld), .ac_din(ac_din), .mem_rdata(mem_rdata),
      .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
      .mem_wdata(mem_wdata), .pc(pc), .ie(ie)
   );

   always @(posedge clk) begin
      if (mem_re) mem_rdata <= mem[mem_addr];
      if (log_clr) wcnt <= 0;
      else if (mem_we) begin
         mem[mem_addr] <= mem_wdata;
         wcnt   <= wcnt + 1;
         last_a <= mem_addr;
         last_d <= mem_wdata;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0; irq = 1'b0; ie_set = 1'b0; ac_ld = 1'b0;
      for (int i = 0; i < 2**AW; i++) mem[i] = '0;
      log_clr = 1'b1;
      cycles(2);
      log_clr = 1'b0;
      rst_n = 1'b1;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      // vector table: STORE modes and no-write opcodes
      for (int v = 0; v < NV; v++) begin
         logic [DW-1:0] ins, ptr, acv;
         logic ew;
         logic [AW-1:0] ea;
         {ins, ptr, acv, ew, ea} = VEC[v];
         do_reset();
         mem[0] = ins;
         if (ins[11]) mem[ins[10:0]] = ptr;
         ac_ld = 1'b1; ac_din = acv;
         cycles(1);
         ac_ld = 1'b0;
         cycles(11);
         // R3 R4 R5: write count, address and data
         chk(wcnt == (ew ? 1 : 0), "R3/R4 write count", wcnt, ew ? 1 : 0);
         if (ew) begin
            chk(last_a == ea, "R5 write address", last_a, ea);
            chk(last_d == acv, "R4 write data", last_d, acv);
         end
      end

      // R1 reset state
      rst_n = 1'b0;
      cycles(1);
      chk(pc == 0, "R1 pc", pc, 0);
      chk(!mem_re && !mem_we, "R1 strobes", {mem_re, mem_we}, 0);
      chk(ie == 1'b0, "R1 ie", ie, 0);

      // R2 first fetch timing
      do_reset();
      chk(!mem_re, "R2 no read in cycle one", mem_re, 0);
      cycles(1);
      chk(mem_re && mem_addr == 0, "R2 read strobe at pc", {mem_re, mem_addr}, {1'b1, 11'h000});
      cycles(1);
      chk(pc == 1, "R2 pc increment", pc, 1);
      chk(!mem_re, "R2 read lasts one cycle", mem_re, 0);

      // R6 interrupt entry after a NOP
      do_reset();
      irq = 1'b1; ie_set = 1'b1;
      cycles(1);
      ie_set = 1'b0;
      chk(ie == 1'b1, "R6 ie set", ie, 1);
      cycles(8);
      chk(pc == ISR_A, "R6 pc loaded", pc, ISR_A);
      chk(mem[SAVE_A] == 16'h0001, "R6 saved pc", mem[SAVE_A], 16'h0001);
      chk(ie == 1'b0, "R6 ie cleared", ie, 0);
      // R7 no re-entry while flag clear
      cycles(20);
      chk(wcnt == 1, "R7 no second entry", wcnt, 1);
      chk(pc == ISR_A + 4, "R7 pc runs on", pc, ISR_A + 4);

      // R7 irq ignored with flag clear
      do_reset();
      irq = 1'b1;
      cycles(12);
      chk(wcnt == 0, "R7 irq ignored writes", wcnt, 0);
      chk(pc == 3, "R7 irq ignored pc", pc, 3);
      irq = 1'b0;

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule